// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Signal Generator

This block watches a small bank of virtual interrupt list entries together with the two virtual group enables and the end-of-interrupt traffic, and from them drives one level-sensitive maintenance interrupt line towards the hypervisor. Each of eight maintenance causes can be switched on or off separately. A global enable for the virtual interface gates every cause.

The per-entry state snapshot, the hardware-link flags and the EOI-request flags come from the list storage, which lives outside this block. EOIs that find no matching list entry arrive as single-cycle pulses. They are counted in a saturating counter, and software clears that counter. The block also reports two bitmaps: one marks the free list entries, the other marks the per-entry end-of-interrupt status. The hypervisor uses these to decide which entries to refill or retire.

Top module: `vmaint_gen`

## Requirements
- R1: While `glb_en` is 0 in a cycle, the next registered `cause_stat` is all zero and `maint_irq` is 0.
- R2: `maint_irq` is high exactly when at least one bit of `cause_stat` is high. It is a level, not a pulse.
- R3: A `cause_stat` bit whose `cause_en` bit was 0 in the sampled cycle is 0.
- R4: Group causes follow the group enables as levels. Bit 4 is group 0 enabled (`grp0_en`=1) and bit 5 is group 0 disabled (`grp0_en`=0). Bit 6 is group 1 enabled and bit 7 is group 1 disabled.
- R5: Bit 2 (no-pending) is set when no entry holds the state code 01 (pending).
- R6: Bit 1 (underflow) is set when at most one entry is valid, meaning its state is not 00.
- R7: Bit 0 (list-EOI) is set when at least one bit of `eoi_map` would be set for the same sampled inputs.
- R8: Each `eoi_miss` pulse adds one to a 5-bit saturating counter (31 is the maximum). `miss_clr` sets the counter to zero and takes precedence over a pulse in the same cycle. Bit 3 (unmatched-EOI) is set while the counter is nonzero.
- R9: `empty_map[i]` is 1 exactly when entry i has state code 00. State codes: 00 free, 01 pending, 10 active, 11 active-and-pending, in `lr_state[2i+1:2i]`.
- R10: `eoi_map[i]` is 1 exactly when entry i is free, its `lr_hw` bit is 0 and its `lr_eoi_req` bit is 1.
- R11: During reset all outputs are 0 and the unmatched-EOI counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global virtual interface enable |
| cause_en | input | 8 | Per-cause enable, bit positions as in cause_stat |
| grp0_en | input | 1 | Virtual group 0 enable |
| grp1_en | input | 1 | Virtual group 1 enable |
| lr_state | input | 2*NUM_LR | Two-bit state code per list entry |
| lr_hw | input | NUM_LR | Hardware-link flag per entry |
| lr_eoi_req | input | NUM_LR | EOI-maintenance request flag per entry |
| eoi_miss | input | 1 | Pulse: an EOI found no valid list entry |
| miss_clr | input | 1 | Software clear of the unmatched-EOI counter |
| maint_irq | output | 1 | Level-sensitive maintenance interrupt |
| cause_stat | output | 8 | Active, enabled maintenance causes |
| empty_map | output | NUM_LR | Free list entries |
| eoi_map | output | NUM_LR | Per-entry end-of-interrupt status |

## Verification
The inputs sampled at a rising edge set `empty_map`, `eoi_map`, `maint_irq` and every cause bit except bit 3, all visible after that edge. One register therefore stands between the inputs and these outputs. The unmatched-EOI cause passes through the counter register first, so it follows a pulse or a clear by two edges. The bench drives inputs on the falling edge and checks at the next falling edge. Its model of the counter holds the value from before the previous edge, so each output is compared with the stimulus that actually reached it.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;
  localparam int CAUSE_W  = 8;
  localparam int C_LEOI   = 0;
  localparam int C_UFLOW  = 1;
  localparam int C_NOPEND = 2;
  localparam int C_MISS   = 3;
  localparam int C_G0ON   = 4;
  localparam int C_G0OFF  = 5;
  localparam int C_G1ON   = 6;
  localparam int C_G1OFF  = 7;

  typedef enum logic [1:0] {
    LR_FREE    = 2'b00,
    LR_PEND    = 2'b01,
    LR_ACT     = 2'b10,
    LR_ACTPEND = 2'b11
  } lr_state_e;
endpackage

// File: rtl/vmaint_lr_scan.sv
module vmaint_lr_scan
  import vmaint_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic [2*NUM_LR-1:0] lr_state,
  input  logic [NUM_LR-1:0]   lr_hw,
  input  logic [NUM_LR-1:0]   lr_eoi_req,
  output logic [NUM_LR-1:0]   free_v,
  output logic [NUM_LR-1:0]   eoi_v,
  output logic                none_pend,
  output logic                few_valid,
  output logic                any_eoi
);
  localparam int CNT_W = $clog2(NUM_LR + 1);

  logic [NUM_LR-1:0] pend_v;
  logic [CNT_W-1:0]  valid_cnt;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
    assign free_v[i] = (lr_state[2*i +: 2] == LR_FREE);
    assign pend_v[i] = (lr_state[2*i +: 2] == LR_PEND);
    assign eoi_v[i]  = free_v[i] & ~lr_hw[i] & lr_eoi_req[i];
  end

  always_comb begin
    valid_cnt = '0;
    for (int k = 0; k < NUM_LR; k++) begin
      valid_cnt = valid_cnt + CNT_W'(~free_v[k]);
    end
  end

  assign none_pend = ~|pend_v;
  assign few_valid = (valid_cnt < CNT_W'(2));
  assign any_eoi   = |eoi_v;
endmodule

// File: rtl/vmaint_miss_ctr.sv
module vmaint_miss_ctr #(
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic miss,
  input  logic clr,
  output logic nonzero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (miss && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign nonzero = |cnt;
endmodule

// File: rtl/vmaint_cause.sv
module vmaint_cause
  import vmaint_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic [CAUSE_W-1:0] cause_en,
  input  logic [CAUSE_W-1:0] raw,
  output logic [CAUSE_W-1:0] cause_stat,
  output logic               maint_irq
);
  logic [CAUSE_W-1:0] gated;

  assign gated = glb_en ? (raw & cause_en) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_stat <= '0;
      maint_irq  <= 1'b0;
    end else begin
      cause_stat <= gated;
      maint_irq  <= |gated;
    end
  end
endmodule

// File: rtl/vmaint_gen.sv
module vmaint_gen
  import vmaint_pkg::*;
#(
  parameter int NUM_LR  = 4,
  parameter int MISS_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                glb_en,
  input  logic [7:0]          cause_en,
  input  logic                grp0_en,
  input  logic                grp1_en,
  input  logic [2*NUM_LR-1:0] lr_state,
  input  logic [NUM_LR-1:0]   lr_hw,
  input  logic [NUM_LR-1:0]   lr_eoi_req,
  input  logic                eoi_miss,
  input  logic                miss_clr,
  output logic                maint_irq,
  output logic [7:0]          cause_stat,
  output logic [NUM_LR-1:0]   empty_map,
  output logic [NUM_LR-1:0]   eoi_map
);
  logic [NUM_LR-1:0]  free_v;
  logic [NUM_LR-1:0]  eoi_v;
  logic               none_pend;
  logic               few_valid;
  logic               any_eoi;
  logic               miss_nz;
  logic [CAUSE_W-1:0] raw;

  vmaint_lr_scan #(.NUM_LR(NUM_LR)) u_scan (
    .lr_state   (lr_state),
    .lr_hw      (lr_hw),
    .lr_eoi_req (lr_eoi_req),
    .free_v     (free_v),
    .eoi_v      (eoi_v),
    .none_pend  (none_pend),
    .few_valid  (few_valid),
    .any_eoi    (any_eoi)
  );

  vmaint_miss_ctr #(.CNT_W(MISS_W)) u_miss (
    .clk     (clk),
    .rst     (rst),
    .miss    (eoi_miss),
    .clr     (miss_clr),
    .nonzero (miss_nz)
  );

  always_comb begin
    raw           = '0;
    raw[C_LEOI]   = any_eoi;
    raw[C_UFLOW]  = few_valid;
    raw[C_NOPEND] = none_pend;
    raw[C_MISS]   = miss_nz;
    raw[C_G0ON]   = grp0_en;
    raw[C_G0OFF]  = ~grp0_en;
    raw[C_G1ON]   = grp1_en;
    raw[C_G1OFF]  = ~grp1_en;
  end

  vmaint_cause u_cause (
    .clk        (clk),
    .rst        (rst),
    .glb_en     (glb_en),
    .cause_en   (cause_en),
    .raw        (raw),
    .cause_stat (cause_stat),
    .maint_irq  (maint_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_map <= '0;
      eoi_map   <= '0;
    end else begin
      empty_map <= free_v;
      eoi_map   <= eoi_v;
    end
  end
endmodule

// File: rtl/vmaint_chk.sv
module vmaint_chk #(
  parameter int NUM_LR = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                glb_en,
  input logic [7:0]          cause_en,
  input logic [2*NUM_LR-1:0] lr_state,
  input logic [NUM_LR-1:0]   lr_hw,
  input logic [NUM_LR-1:0]   lr_eoi_req,
  input logic                maint_irq,
  input logic [7:0]          cause_stat,
  input logic [NUM_LR-1:0]   empty_map,
  input logic [NUM_LR-1:0]   eoi_map
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  function automatic logic [NUM_LR-1:0] free_of(input logic [2*NUM_LR-1:0] s);
    for (int i = 0; i < NUM_LR; i++) free_of[i] = (s[2*i +: 2] == 2'b00);
  endfunction

  function automatic logic has_pend(input logic [2*NUM_LR-1:0] s);
    has_pend = 1'b0;
    for (int i = 0; i < NUM_LR; i++) if (s[2*i +: 2] == 2'b01) has_pend = 1'b1;
  endfunction

  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(glb_en)) |-> (!maint_irq && cause_stat == 8'h00));

  p_level_r2: assert property (@(posedge clk) disable iff (rst)
    maint_irq == (|cause_stat));

  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((cause_stat & ~$past(cause_en)) == 8'h00));

  p_nopend_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cause_stat[2]) |-> !has_pend($past(lr_state)));

  p_free_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (empty_map == free_of($past(lr_state))));

  p_eoimap_r10: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (eoi_map == (free_of($past(lr_state)) & ~$past(lr_hw) & $past(lr_eoi_req))));
endmodule

bind vmaint_gen vmaint_chk #(.NUM_LR(NUM_LR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .glb_en     (glb_en),
  .cause_en   (cause_en),
  .lr_state   (lr_state),
  .lr_hw      (lr_hw),
  .lr_eoi_req (lr_eoi_req),
  .maint_irq  (maint_irq),
  .cause_stat (cause_stat),
  .empty_map  (empty_map),
  .eoi_map    (eoi_map)
);

// File: tb/vmaint_gen_tb.sv
module vmaint_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         glb_en = 1'b0;
  logic [7:0]   cause_en = 8'h00;
  logic         grp0_en = 1'b0;
  logic         grp1_en = 1'b0;
  logic [2*N-1:0] lr_state = '0;
  logic [N-1:0] lr_hw = '0;
  logic [N-1:0] lr_eoi_req = '0;
  logic         eoi_miss = 1'b0;
  logic         miss_clr = 1'b0;
  logic         maint_irq;
  logic [7:0]   cause_stat;
  logic [N-1:0] empty_map;
  logic [N-1:0] eoi_map;

  int n_chk = 0;
  int n_bad = 0;
  int mcnt  = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmaint_gen #(.NUM_LR(N), .MISS_W(5)) u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .cause_en(cause_en),
    .grp0_en(grp0_en), .grp1_en(grp1_en), .lr_state(lr_state),
    .lr_hw(lr_hw), .lr_eoi_req(lr_eoi_req), .eoi_miss(eoi_miss),
    .miss_clr(miss_clr), .maint_irq(maint_irq), .cause_stat(cause_stat),
    .empty_map(empty_map), .eoi_map(eoi_map)
  );

  function automatic logic [N-1:0] m_free(input logic [2*N-1:0] s);
    for (int i = 0; i < N; i++) m_free[i] = (s[2*i +: 2] == 2'b00);
  endfunction

  function automatic logic [N-1:0] m_eoi(input logic [2*N-1:0] s,
      input logic [N-1:0] hw, input logic [N-1:0] rq);
    m_eoi = m_free(s) & ~hw & rq;
  endfunction

  function automatic logic [7:0] m_cause(input int cnt);
    logic [7:0] r;
    int nv;
    logic pend;
    nv = 0;
    pend = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lr_state[2*i +: 2] != 2'b00) nv++;
      if (lr_state[2*i +: 2] == 2'b01) pend = 1'b1;
    end
    r[0] = |m_eoi(lr_state, lr_hw, lr_eoi_req);
    r[1] = (nv <= 1);
    r[2] = !pend;
    r[3] = (cnt != 0);
    r[4] = grp0_en;
    r[5] = !grp0_en;
    r[6] = grp1_en;
    r[7] = !grp1_en;
    m_cause = glb_en ? (r & cause_en) : 8'h00;
  endfunction

  function automatic string tag_of(input int b);
    if (!glb_en)      return "R1";
    if (!cause_en[b]) return "R3";
    case (b)
      0: return "R7";
      1: return "R6";
      2: return "R5";
      3: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compares the outputs with the inputs applied one edge earlier, then advances the counter model
  task automatic tick();
    logic [7:0] ec;
    @(negedge clk);
    ec = m_cause(mcnt);
    for (int b = 0; b < 8; b++) chk(tag_of(b), {31'd0, cause_stat[b]}, {31'd0, ec[b]});
    chk("R2", {31'd0, maint_irq}, {31'd0, |ec});
    chk("R9", {28'd0, empty_map}, {28'd0, m_free(lr_state)});
    chk("R10", {28'd0, eoi_map}, {28'd0, m_eoi(lr_state, lr_hw, lr_eoi_req)});
    if (miss_clr)                   mcnt = 0;
    else if (eoi_miss && mcnt < 31) mcnt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", {28'd0, maint_irq, cause_stat[2:0]}, 32'd0);
    chk("R11", {24'd0, cause_stat}, 32'd0);
    chk("R11", {24'd0, empty_map, eoi_map}, 32'd0);
    rst = 1'b0;
    tick();
    // R6 R5: all free, everything enabled
    glb_en = 1'b1; cause_en = 8'hFF; tick();
    // R5: all pending
    lr_state = 8'h55; tick();
    // R6: exactly one valid
    lr_state = 8'h02; tick();
    // R6: two valid, no pending code 01 but active-and-pending present
    lr_state = 8'h3C; tick();
    // R4: group combinations
    grp0_en = 1'b1; tick();
    grp1_en = 1'b1; grp0_en = 1'b0; tick();
    // R10 R7: free entry with request, hw link blocks other
    lr_state = 8'h50; lr_hw = 4'b0010; lr_eoi_req = 4'b0011; tick();
    lr_hw = 4'b0011; tick();
    lr_hw = 4'b0000; lr_eoi_req = 4'b1100; tick();
    lr_eoi_req = 4'b0000;
    // R8: a single miss pulse shows up two edges later
    eoi_miss = 1'b1; tick();
    eoi_miss = 1'b0; tick(); tick();
    // R8: saturate then a single clear empties the counter
    eoi_miss = 1'b1; repeat (40) tick();
    eoi_miss = 1'b0; miss_clr = 1'b1; tick();
    miss_clr = 1'b0; tick(); tick();
    // R8: clear and pulse together, clear wins
    eoi_miss = 1'b1; miss_clr = 1'b1; tick();
    eoi_miss = 1'b0; miss_clr = 1'b0; tick(); tick();
    // R1: global enable off with every condition live
    eoi_miss = 1'b1; tick(); eoi_miss = 1'b0;
    glb_en = 1'b0; lr_state = 8'h00; lr_eoi_req = 4'hF; tick(); tick();
    // R3: single cause enabled
    glb_en = 1'b1; cause_en = 8'h02; tick(); tick();
    // random phase
    for (int c = 0; c < 3000; c++) begin
      glb_en     = ($urandom_range(0, 7) != 0);
      cause_en   = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
      grp0_en    = 1'($urandom);
      grp1_en    = 1'($urandom);
      lr_state   = 8'($urandom);
      if ($urandom_range(0, 3) == 0) lr_state = 8'h00;
      lr_hw      = 4'($urandom);
      lr_eoi_req = 4'($urandom);
      eoi_miss   = ($urandom_range(0, 5) == 0);
      miss_clr   = ($urandom_range(0, 15) == 0);
      tick();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule